// File: doc/BRIEF.md
# Device-Side Address Translation Cache

This block sits inside one function of an I/O endpoint, between the engine that issues DMA requests and the link. It keeps a small set of page translations the function has recently obtained, so that outgoing DMA can carry an already-translated address. Each function instantiates its own copy, so the cache never holds another function's translations.

An incoming DMA request is looked up by its 4 KiB page number. On a hit the request leaves in the same cycle, steered either as a translated access (physical page plus the untouched page offset) or, when the entry records that no translation exists, as an untranslated access carrying the original address. On a miss the request is stalled, a single translation request tagged with the function's routing ID is sent upstream over a valid/ready handshake, and the cache waits for the completion. A successful completion fills an entry with the physical page number; a failed one fills an entry marked "no translation", so that page is never asked for again until the entry is evicted or flushed. Replacement is round robin over a fully associative array, and a synchronous flush empties the whole array in one cycle.

Top module: `xlat_cache`

## Requirements
- R1: After reset the cache is empty, no outgoing DMA is valid, no translation request is valid and the completion port is not ready.
- R2: A DMA request whose page (address bits 31:12) is not cached is stalled (out_valid and dma_ready low) and, one cycle later, causes a translation request whose page field equals the request's page and whose routing ID field equals rid_i.
- R3: A translation request stays valid with an unchanged page until accepted, and after acceptance no further request is issued until a completion has been taken.
- R4: A completion with cpl_ok=1 fills an entry; the stalled request then leaves with out_translated=1 and out_addr equal to the returned physical page in bits 31:12 and the request's own bits 11:0.
- R5: A completion with cpl_ok=0 fills an entry marked as having no translation; requests to that page leave with out_translated=0 and out_addr equal to dma_addr, without any new translation request.
- R6: A request that hits leaves in the same cycle it is presented, and dma_ready follows out_ready while out_valid is high.
- R7: The array holds 8 entries filled in round-robin order: the ninth distinct fill replaces the oldest fill, and the other seven pages still hit.
- R8: A one-cycle flush removes every entry, so every page misses afterwards; the round-robin position is not changed by a flush.
- R9: Any page may occupy any entry, and at most one entry matches a page.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Clear all entries in one cycle |
| rid_i | input | 16 | Routing ID of the owning function |
| dma_valid | input | 1 | DMA request present |
| dma_ready | output | 1 | DMA request accepted |
| dma_addr | input | 32 | Untranslated DMA address |
| out_valid | output | 1 | Outgoing DMA present |
| out_ready | input | 1 | Link accepts outgoing DMA |
| out_addr | output | 32 | Outgoing address (translated or original) |
| out_translated | output | 1 | 1 when out_addr is translated |
| xreq_valid | output | 1 | Translation request present |
| xreq_ready | input | 1 | Translation request accepted |
| xreq_vpn | output | 20 | Page number to translate |
| xreq_rid | output | 16 | Routing ID attached to the request |
| xcpl_valid | input | 1 | Translation completion present |
| xcpl_ready | output | 1 | Completion accepted |
| xcpl_ok | input | 1 | 1 when a translation exists |
| xcpl_ppn | input | 20 | Returned physical page number |

## Verification
The assertions assume that a stalled DMA request keeps dma_valid high with an unchanged address until it leaves, that completions arrive only after a translation request has been accepted, and that flush is not raised in the cycle a completion is taken. The bench drives one request at a time and holds it until out_valid is seen, plays the translation agent itself with a page-derived success rule and physical page, answers each request exactly once, and raises flush only while the cache is idle. A reference array in the bench with its own round-robin counter predicts hit or miss for a long page sequence chosen to force evictions.

// File: rtl/xc_pkg.sv
package xc_pkg;
  typedef enum logic [1:0] {
    XS_IDLE = 2'd0,
    XS_REQ  = 2'd1,
    XS_WAIT = 2'd2
  } xs_state_e;
endpackage

// File: rtl/xc_tag_array.sv
module xc_tag_array #(
  parameter int ENTRIES = 8,
  parameter int VPN_W   = 20,
  parameter int PPN_W   = 20,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic [VPN_W-1:0] lk_vpn,
  output logic             lk_hit,
  output logic             lk_neg,
  output logic [PPN_W-1:0] lk_ppn,
  input  logic             fill_en,
  input  logic [IDX_W-1:0] fill_idx,
  input  logic             fill_neg,
  input  logic [VPN_W-1:0] fill_vpn,
  input  logic [PPN_W-1:0] fill_ppn
);
  logic [ENTRIES-1:0] valid_q, neg_q, match;
  logic [VPN_W-1:0]   vpn_q [ENTRIES];
  logic [PPN_W-1:0]   ppn_q [ENTRIES];

  for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
    logic sel;
    assign sel      = fill_en && (fill_idx == IDX_W'(i));
    assign match[i] = valid_q[i] && (vpn_q[i] == lk_vpn);
    always_ff @(posedge clk) begin
      if (!rst_n || flush) begin
        valid_q[i] <= 1'b0;
        neg_q[i]   <= 1'b0;
      end else if (sel) begin
        valid_q[i] <= 1'b1;
        neg_q[i]   <= fill_neg;
      end
    end
    always_ff @(posedge clk) begin
      if (sel) begin
        vpn_q[i] <= fill_vpn;
        ppn_q[i] <= fill_ppn;
      end
    end
  end

  always_comb begin
    lk_hit = |match;
    lk_neg = 1'b0;
    lk_ppn = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (match[i]) begin
        lk_neg = lk_neg | neg_q[i];
        lk_ppn = lk_ppn | ppn_q[i];
      end
    end
  end

  // R9: a page never sits in two entries
  p_single_match_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(match));
  // R8: flush empties the array by the next cycle
  p_flush_empty_r8: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (valid_q == '0));
  // R4: a fill leaves its entry valid
  p_fill_valid_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_en && !flush) |=> valid_q[$past(fill_idx)]);
endmodule

// File: rtl/xc_victim_ptr.sv
module xc_victim_ptr #(
  parameter int ENTRIES = 8,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             advance,
  output logic [IDX_W-1:0] ptr
);
  function automatic logic [IDX_W-1:0] next_slot(input logic [IDX_W-1:0] cur);
    return (cur == IDX_W'(ENTRIES - 1)) ? '0 : cur + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n)       ptr <= '0;
    else if (advance) ptr <= next_slot(ptr);
  end

  // R7: each fill moves the victim to another slot
  p_ptr_moves_r7: assert property (@(posedge clk) disable iff (!rst_n)
    advance |=> (ptr != $past(ptr)));
endmodule

// File: rtl/xc_miss_fsm.sv
module xc_miss_fsm
  import xc_pkg::*;
#(
  parameter int VPN_W = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             miss,
  input  logic [VPN_W-1:0] miss_vpn,
  output logic             req_valid,
  input  logic             req_ready,
  output logic [VPN_W-1:0] req_vpn,
  input  logic             cpl_valid,
  output logic             cpl_ready,
  output logic             busy,
  output logic             fill_now
);
  xs_state_e state_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= XS_IDLE;
    end else begin
      unique case (state_q)
        XS_IDLE: if (miss)                   state_q <= XS_REQ;
        XS_REQ:  if (req_ready)              state_q <= XS_WAIT;
        XS_WAIT: if (cpl_valid)              state_q <= XS_IDLE;
        default:                             state_q <= XS_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (state_q == XS_IDLE && miss) req_vpn <= miss_vpn;
  end

  assign req_valid = (state_q == XS_REQ);
  assign cpl_ready = (state_q == XS_WAIT);
  assign busy      = (state_q != XS_IDLE);
  assign fill_now  = cpl_ready && cpl_valid;

  // R3: request held stable until accepted
  p_req_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> (req_valid && $stable(req_vpn)));
  // R3: one request outstanding at a time
  p_one_outstanding_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_valid);
endmodule

// File: rtl/xlat_cache.sv
module xlat_cache #(
  parameter int ENTRIES    = 8,
  parameter int ADDR_W     = 32,
  parameter int PAGE_SHIFT = 12,
  parameter int RID_W      = 16,
  localparam int VPN_W     = ADDR_W - PAGE_SHIFT,
  localparam int IDX_W     = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic [RID_W-1:0]  rid_i,
  input  logic              dma_valid,
  output logic              dma_ready,
  input  logic [ADDR_W-1:0] dma_addr,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [ADDR_W-1:0] out_addr,
  output logic              out_translated,
  output logic              xreq_valid,
  input  logic              xreq_ready,
  output logic [VPN_W-1:0]  xreq_vpn,
  output logic [RID_W-1:0]  xreq_rid,
  input  logic              xcpl_valid,
  output logic              xcpl_ready,
  input  logic              xcpl_ok,
  input  logic [VPN_W-1:0]  xcpl_ppn
);
  function automatic logic [VPN_W-1:0] page_of(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1:PAGE_SHIFT];
  endfunction

  function automatic logic [ADDR_W-1:0] join_page(input logic [VPN_W-1:0] p,
                                                  input logic [ADDR_W-1:0] a);
    return {p, a[PAGE_SHIFT-1:0]};
  endfunction

  logic             lk_hit, lk_neg, busy, miss, fill_now;
  logic [VPN_W-1:0] lk_ppn;
  logic [IDX_W-1:0] victim;

  assign miss = dma_valid && !lk_hit && !busy;

  xc_tag_array #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .PPN_W(VPN_W)) tags_i (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .lk_vpn(page_of(dma_addr)), .lk_hit(lk_hit), .lk_neg(lk_neg), .lk_ppn(lk_ppn),
    .fill_en(fill_now), .fill_idx(victim), .fill_neg(!xcpl_ok),
    .fill_vpn(xreq_vpn), .fill_ppn(xcpl_ppn)
  );

  xc_victim_ptr #(.ENTRIES(ENTRIES)) victim_i (
    .clk(clk), .rst_n(rst_n), .advance(fill_now), .ptr(victim)
  );

  xc_miss_fsm #(.VPN_W(VPN_W)) fsm_i (
    .clk(clk), .rst_n(rst_n), .miss(miss), .miss_vpn(page_of(dma_addr)),
    .req_valid(xreq_valid), .req_ready(xreq_ready), .req_vpn(xreq_vpn),
    .cpl_valid(xcpl_valid), .cpl_ready(xcpl_ready),
    .busy(busy), .fill_now(fill_now)
  );

  assign xreq_rid       = rid_i;
  assign out_valid      = dma_valid && lk_hit && !busy;
  assign dma_ready      = out_valid && out_ready;
  assign out_translated = !lk_neg;
  assign out_addr       = lk_neg ? dma_addr : join_page(lk_ppn, dma_addr);

  // R2: nothing leaves while a translation is pending
  p_stall_on_miss_r2: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (!out_valid && !dma_ready));
  // R5: untranslated accesses keep the address unchanged
  p_neg_passthru_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_translated) |-> (out_addr == dma_addr));
  // R1: no completion is taken before a request went out
  p_cpl_after_req_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(xcpl_ready) |-> $past(xreq_valid && xreq_ready));
endmodule

// File: tb/xlat_cache_tb_top.sv
`timescale 1ns/1ps
module xlat_cache_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        flush = 1'b0;
  logic [15:0] rid_i = 16'h0123;
  logic        dma_valid = 1'b0, dma_ready;
  logic [31:0] dma_addr = '0;
  logic        out_valid, out_ready = 1'b1, out_translated;
  logic [31:0] out_addr;
  logic        xreq_valid, xreq_ready = 1'b0;
  logic [19:0] xreq_vpn, xcpl_ppn = '0;
  logic [15:0] xreq_rid;
  logic        xcpl_valid = 1'b0, xcpl_ready, xcpl_ok = 1'b0;

  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  xlat_cache dut_i (.*);

  // reference state
  logic [19:0] m_vpn [8];
  logic        m_val [8];
  int          m_rr = 0;

  function automatic logic agent_ok(input logic [19:0] v);
    return (v % 3) != 0;
  endfunction
  function automatic logic [19:0] agent_ppn(input logic [19:0] v);
    return 20'(v * 5 + 20'h3C3);
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  task automatic do_dma(input logic [31:0] a, input string tag);
    logic [19:0] v;
    logic exp_hit;
    v = a[31:12];
    exp_hit = 1'b0;
    for (int i = 0; i < 8; i++) if (m_val[i] && m_vpn[i] == v) exp_hit = 1'b1;
    @(negedge clk);
    dma_valid = 1'b1; dma_addr = a;
    #1;
    chk({tag, " R7 R9 hit"}, out_valid, exp_hit);
    if (!exp_hit) begin
      chk("R2 stall", dma_ready, 1'b0);
      @(negedge clk); #1;
      chk("R2 req valid", xreq_valid, 1'b1);
      chk("R2 req page", xreq_vpn, v);
      chk("R2 req rid", xreq_rid, rid_i);
      @(negedge clk); #1;
      chk("R3 req held", {xreq_valid, xreq_vpn}, {1'b1, v});
      xreq_ready = 1'b1;
      @(negedge clk);
      xreq_ready = 1'b0; #1;
      chk("R3 no second req", xreq_valid, 1'b0);
      chk("R2 still stalled", out_valid, 1'b0);
      xcpl_valid = 1'b1; xcpl_ok = agent_ok(v); xcpl_ppn = agent_ppn(v);
      @(negedge clk);
      xcpl_valid = 1'b0; #1;
      m_vpn[m_rr] = v; m_val[m_rr] = 1'b1; m_rr = (m_rr + 1) % 8;
      chk("R4 R5 filled then hits", out_valid, 1'b1);
    end
    if (agent_ok(v)) begin
      chk("R4 translated flag", out_translated, 1'b1);
      chk("R4 translated addr", out_addr, {agent_ppn(v), a[11:0]});
    end else begin
      chk("R5 untranslated flag", out_translated, 1'b0);
      chk("R5 original addr", out_addr, a);
    end
    chk("R6 ready follows", dma_ready, out_ready);
    @(negedge clk);
    dma_valid = 1'b0;
  endtask

  function automatic logic [31:0] page_addr(input int k, input int off);
    return {20'(20'h00010 + k * 20'h01003), 12'(off)};
  endfunction

  initial begin
    for (int i = 0; i < 8; i++) m_val[i] = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R1 out idle", out_valid, 1'b0);
    chk("R1 req idle", xreq_valid, 1'b0);
    chk("R1 cpl not ready", xcpl_ready, 1'b0);
    // sweep with evictions
    for (int i = 0; i < 70; i++) do_dma(page_addr((i * 3 + i / 5) % 11, i * 499), "sweep");
    // R7: fill 9 fresh pages, first one evicted, rest hit
    for (int k = 20; k < 29; k++) do_dma(page_addr(k, k), "R7 fill");
    for (int k = 21; k < 29; k++) do_dma(page_addr(k, 7), "R7 kept");
    do_dma(page_addr(20, 1), "R7 evicted");
    // R6: backpressure on a hit
    @(negedge clk);
    out_ready = 1'b0; dma_valid = 1'b1; dma_addr = page_addr(22, 5);
    #1;
    chk("R6 valid under backpressure", out_valid, 1'b1);
    chk("R6 not accepted", dma_ready, 1'b0);
    @(negedge clk);
    out_ready = 1'b1; dma_valid = 1'b0;
    // R8: flush
    @(negedge clk); flush = 1'b1;
    @(negedge clk); flush = 1'b0;
    for (int i = 0; i < 8; i++) m_val[i] = 1'b0;
    for (int k = 22; k < 26; k++) do_dma(page_addr(k, 3), "R8 after flush");
    for (int k = 22; k < 26; k++) do_dma(page_addr(k, 9), "R8 refilled");
    finish_run();
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run();
  end
endmodule